// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial characters on one output line. Each character is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit and 1, 1.5 or 2 high stop bits. Character length, parity and stop length are run-time inputs. All serial timing comes from a transmit clock enable (`tick`) that is one cycle wide. One bit cell lasts 1, 16 or 64 ticks, as chosen by the baud factor code. The line only changes on a cycle in which `tick` is high.

The block is double buffered. The host writes into a one-byte holding register while the previous character is still being shifted out. The holding register passes its byte to the shifter only when the shifter has nothing left to send. The shifter starts a new character only when transmit is enabled and the clear-to-send input is low. Two flags report the state of the buffers: `tx_rdy` shows that the holding register can take a byte, and `tx_empty` shows that nothing at all is left to send. A break input holds the line low for as long as it is set, whatever the shifter is doing.

Top module: `async_tx`

## Requirements
- R1: After reset, `txd` is 1, `tx_rdy` is 1 and `tx_empty` is 1.
- R2: One bit cell lasts F ticks, where `cfg_baud` 2'b10 gives F=16, 2'b11 gives F=64, and 2'b01 or 2'b00 gives F=1. The line changes only on a tick edge.
- R3: A character is a start bit at 0, followed by N data bits with the LSB first. N is 5, 6, 7 or 8 for `cfg_len` values 2'b00, 2'b01, 2'b10 and 2'b11.
- R4: When `cfg_par_en`=1, one parity bit follows the data. It is computed over the N data bits only. With `cfg_par_even`=1 the total count of ones, parity included, is even; with `cfg_par_even`=0 it is odd. When `cfg_par_en`=0, no parity bit is sent.
- R5: The stop period is high. `cfg_stop` 2'b10 makes it 1.5·F ticks, or 2 ticks when F=1. 2'b11 makes it 2·F ticks. 2'b01 or 2'b00 makes it F ticks. The line stays high while idle.
- R6: `tx_rdy` is 0 in the cycle after a write is accepted, and returns to 1 once the byte has moved to the shifter. A write while `tx_rdy` is 0 is ignored.
- R7: A held byte moves to the shifter only after the current stop period ends. If a byte is already waiting, its start bit begins on the tick that ends the previous stop period, with no idle gap.
- R8: `tx_empty` is 1 exactly when both the holding register and the shifter are empty. Whenever `tx_empty` is 1, `tx_rdy` is also 1.
- R9: A character starts only when `tx_en`=1 and `cts_n`=0. Otherwise a held byte stays held and the line stays high.
- R10: The cycle after `send_break` is seen high, `txd` is 0. It stays 0 for as long as `send_break` stays high.
- R11: When no tick and no break are present in the two preceding cycles, `txd` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Transmit clock enable, one cycle wide |
| cfg_baud | input | 2 | Baud factor code |
| cfg_len | input | 2 | Character length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stop | input | 2 | Stop length code |
| tx_en | input | 1 | Transmit enable |
| cts_n | input | 1 | Clear to send, active low |
| send_break | input | 1 | Force the line low |
| wr_en | input | 1 | Host write strobe, one cycle |
| wr_data | input | 8 | Byte to send |
| txd | output | 1 | Serial line |
| tx_rdy | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Nothing left to send |

## Verification
Random bytes are sent under random character formats, with the tick arriving either every cycle or on about half of the cycles. Every cell of the line log is compared with the expected frame, so a wrong cell length is told apart from a wrong bit order or a wrong parity sense. Directed sequences cover the following cases:
- A write into a full holding register, which must add no frame.
- A start held back by the clear-to-send input or by the enable input.
- Two bytes queued back to back, which must leave no idle gap.
- A pause in the ticks in the middle of a frame.
- Break held while the line is idle.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } fr_state_e;

    // parity over the configured number of data bits
    function automatic logic char_parity(input logic [7:0] d,
                                         input logic [1:0] len,
                                         input logic even);
        logic [7:0] m;
        m = 8'hFF >> (3'd3 - {1'b0, len});
        return even ? (^(d & m)) : ~(^(d & m));
    endfunction

endpackage

// File: rtl/tx_len_calc.sv
module tx_len_calc #(
    parameter int FAC_MID = 16,
    parameter int FAC_HI  = 64,
    parameter int CNT_W   = $clog2(2 * FAC_HI + 1)
) (
    input  logic [1:0]       baud,
    input  logic [1:0]       stop,
    output logic [CNT_W-1:0] bit_ticks,
    output logic [CNT_W-1:0] stop_ticks
);
    logic [CNT_W-1:0] fac;

    always_comb begin
        unique case (baud)
            2'b10:   fac = CNT_W'(FAC_MID);
            2'b11:   fac = CNT_W'(FAC_HI);
            default: fac = CNT_W'(1);
        endcase
        bit_ticks = fac;
        unique case (stop)
            2'b10:   stop_ticks = (fac == CNT_W'(1)) ? CNT_W'(2) : fac + (fac >> 1);
            2'b11:   stop_ticks = fac << 1;
            default: stop_ticks = fac;
        endcase
    end
endmodule

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) begin
            hold_d.full = 1'b0;
        end
        if (wr_en && !hold_q.full) begin
            hold_d.full = 1'b1;
            hold_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign full = hold_q.full;
    assign data = hold_q.data;
endmodule

// File: rtl/tx_framer.sv
module tx_framer
    import async_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go_ok,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [1:0]        len,
    input  logic              par_en,
    input  logic              par_even,
    input  logic [CNT_W-1:0]  bit_ticks,
    input  logic [CNT_W-1:0]  stop_ticks,
    input  logic              brk,
    output logic              take,
    output logic              busy,
    output logic              line
);
    localparam int IDX_W = $clog2(DATA_W);

    typedef struct packed {
        fr_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  bidx;
        logic [DATA_W-1:0] sh;
        logic              par;
        logic              fbit;
        logic              line;
    } fr_t;

    fr_t fr_d, fr_q;
    logic             start_ok;
    logic             do_load;
    logic             cell_end;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        fr_d     = fr_q;
        do_load  = 1'b0;
        start_ok = hold_full && go_ok;
        cell_end = (fr_q.cnt == bit_ticks - CNT_W'(1));
        last_idx = IDX_W'(len) + IDX_W'(4);
        if (tick) begin
            unique case (fr_q.state)
                ST_IDLE: begin
                    do_load = start_ok;
                end
                ST_START: begin
                    if (cell_end) begin
                        fr_d.state = ST_DATA;
                        fr_d.cnt   = '0;
                        fr_d.bidx  = '0;
                        fr_d.fbit  = fr_q.sh[0];
                    end else begin
                        fr_d.cnt = fr_q.cnt + CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (cell_end) begin
                        fr_d.cnt = '0;
                        if (fr_q.bidx == last_idx) begin
                            if (par_en) begin
                                fr_d.state = ST_PAR;
                                fr_d.fbit  = fr_q.par;
                            end else begin
                                fr_d.state = ST_STOP;
                                fr_d.fbit  = 1'b1;
                            end
                        end else begin
                            fr_d.bidx = fr_q.bidx + IDX_W'(1);
                            fr_d.fbit = fr_q.sh[1];
                            fr_d.sh   = fr_q.sh >> 1;
                        end
                    end else begin
                        fr_d.cnt = fr_q.cnt + CNT_W'(1);
                    end
                end
                ST_PAR: begin
                    if (cell_end) begin
                        fr_d.state = ST_STOP;
                        fr_d.cnt   = '0;
                        fr_d.fbit  = 1'b1;
                    end else begin
                        fr_d.cnt = fr_q.cnt + CNT_W'(1);
                    end
                end
                ST_STOP: begin
                    if (fr_q.cnt == stop_ticks - CNT_W'(1)) begin
                        if (start_ok) begin
                            do_load = 1'b1;
                        end else begin
                            fr_d.state = ST_IDLE;
                            fr_d.cnt   = '0;
                        end
                    end else begin
                        fr_d.cnt = fr_q.cnt + CNT_W'(1);
                    end
                end
                default: begin
                    fr_d.state = ST_IDLE;
                    fr_d.fbit  = 1'b1;
                end
            endcase
        end
        if (do_load) begin
            fr_d.state = ST_START;
            fr_d.cnt   = '0;
            fr_d.bidx  = '0;
            fr_d.sh    = hold_data;
            fr_d.par   = char_parity(hold_data, len, par_even);
            fr_d.fbit  = 1'b0;
        end
        fr_d.line = brk ? 1'b0 : fr_d.fbit;
        take      = do_load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q       <= '0;
            fr_q.state <= ST_IDLE;
            fr_q.fbit  <= 1'b1;
            fr_q.line  <= 1'b1;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign busy = (fr_q.state != ST_IDLE);
    assign line = fr_q.line;
endmodule

// File: rtl/async_tx.sv
module async_tx #(
    parameter int DATA_W  = 8,
    parameter int FAC_MID = 16,
    parameter int FAC_HI  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        cfg_baud,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic [1:0]        cfg_stop,
    input  logic              tx_en,
    input  logic              cts_n,
    input  logic              send_break,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_rdy,
    output logic              tx_empty
);
    localparam int CNT_W = $clog2(2 * FAC_HI + 1);

    logic [CNT_W-1:0]  bit_ticks;
    logic [CNT_W-1:0]  stop_ticks;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              busy;

    tx_len_calc #(
        .FAC_MID(FAC_MID),
        .FAC_HI (FAC_HI),
        .CNT_W  (CNT_W)
    ) i_len (
        .baud      (cfg_baud),
        .stop      (cfg_stop),
        .bit_ticks (bit_ticks),
        .stop_ticks(stop_ticks)
    );

    tx_hold_buf #(
        .DATA_W(DATA_W)
    ) i_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .take   (take),
        .full   (hold_full),
        .data   (hold_data)
    );

    tx_framer #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) i_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .go_ok     (tx_en && !cts_n),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .len       (cfg_len),
        .par_en    (cfg_par_en),
        .par_even  (cfg_par_even),
        .bit_ticks (bit_ticks),
        .stop_ticks(stop_ticks),
        .brk       (send_break),
        .take      (take),
        .busy      (busy),
        .line      (txd)
    );

    assign tx_rdy   = !hold_full;
    assign tx_empty = !hold_full && !busy;
endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              tx_en,
    input logic              cts_n,
    input logic              send_break,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              txd,
    input logic              tx_rdy,
    input logic              tx_empty
);
    // R6: an accepted write leaves the holding register full next cycle
    p_rdy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_rdy) |=> !tx_rdy);

    // R8: empty implies ready
    p_empty_rdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_rdy);

    // R9: with transmit disabled a held byte stays held
    p_gate_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_rdy && !tx_en) |=> !tx_rdy);

    // R9: with clear-to-send high a held byte stays held
    p_cts_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_rdy && cts_n) |=> !tx_rdy);

    // R10: break forces the line low one cycle later
    p_break_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        send_break |=> !txd);

    // R5: idle line is mark
    p_idle_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !$past(send_break)) |-> txd);

    // R11: no tick and no break means no change
    p_quiet_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && !$past(send_break) && !$past(send_break, 2)) |-> $stable(txd));
endmodule

bind async_tx async_tx_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_async_tx.sv
`timescale 1ns/1ps
module test_async_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] cfg_baud = 2'b01;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic [1:0] cfg_stop = 2'b01;
    logic       tx_en = 1'b0;
    logic       cts_n = 1'b1;
    logic       send_break = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd;
    logic       tx_rdy;
    logic       tx_empty;

    int total = 0;
    int bad = 0;
    int tick_pct = 100;
    bit tk = 1'b0;
    bit log_q[$];

    async_tx i_async_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_baud(cfg_baud),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_stop(cfg_stop), .tx_en(tx_en), .cts_n(cts_n),
        .send_break(send_break), .wr_en(wr_en), .wr_data(wr_data),
        .txd(txd), .tx_rdy(tx_rdy), .tx_empty(tx_empty)
    );

    always #2.5 clk = ~clk;

    initial forever begin
        @(negedge clk);
        tick <= (int'($urandom_range(99)) < tick_pct);
    end

    initial forever begin
        @(posedge clk);
        tk = tick && rst_n;
    end

    initial forever begin
        @(negedge clk);
        if (tk) log_q.push_back(txd);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int fac_of(input logic [1:0] b);
        return (b == 2'b10) ? 16 : (b == 2'b11) ? 64 : 1;
    endfunction

    function automatic int stop_of(input logic [1:0] b, input logic [1:0] s);
        int f = fac_of(b);
        if (s == 2'b10) return (f == 1) ? 2 : f + f / 2;
        if (s == 2'b11) return 2 * f;
        return f;
    endfunction

    function automatic int nbits_of(input logic [1:0] l);
        return int'(l) + 5;
    endfunction

    function automatic bit par_of(input logic [7:0] d, input logic [1:0] l, input bit even);
        int ones = 0;
        for (int i = 0; i < nbits_of(l); i++) ones += d[i];
        return even ? bit'(ones % 2) : bit'(1 - ones % 2);
    endfunction

    function automatic int flen();
        return fac_of(cfg_baud) * (1 + nbits_of(cfg_len) + (cfg_par_en ? 1 : 0))
               + stop_of(cfg_baud, cfg_stop);
    endfunction

    function automatic bit cell_ok(input int s, input int n, input bit v);
        if (s + n > log_q.size()) return 1'b0;
        for (int j = 0; j < n; j++) if (log_q[s + j] != v) return 1'b0;
        return 1'b1;
    endfunction

    task automatic wait_ticks(input int n);
        int seen = 0;
        while (seen < n) begin
            @(posedge clk);
            if (tick) seen++;
        end
        @(negedge clk);
    endtask

    task automatic wait_empty();
        int i = 0;
        @(negedge clk);
        while (!tx_empty && i < 30000) begin
            @(negedge clk);
            i++;
        end
        chk(tx_empty == 1'b1, "R8", "empty after drain", tx_empty, 1);
        wait_ticks(4);
    endtask

    task automatic wr_byte(input logic [7:0] d);
        int i = 0;
        while (!tx_rdy && i < 30000) begin
            @(negedge clk);
            i++;
        end
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk(tx_rdy == 1'b0, "R6", "ready low after write", tx_rdy, 0);
    endtask

    // decode the log from index 'from'; gapless asks for back-to-back starts
    task automatic check_stream(input int from, input logic [7:0] exp[$], input bit gapless);
        int k = from;
        int f = fac_of(cfg_baud);
        int n = nbits_of(cfg_len);
        int prev_end = -1;
        foreach (exp[e]) begin
            while (k < log_q.size() && log_q[k] == 1'b1) k++;
            if (k >= log_q.size()) begin
                chk(1'b0, "R3", "frame missing", e, exp.size());
                return;
            end
            if (gapless && prev_end >= 0)
                chk(k == prev_end, "R7", "back-to-back start tick", k, prev_end);
            chk(cell_ok(k, f, 1'b0), "R3", "start cell", int'(log_q[k]), 0);
            begin
                bit ok = 1'b1;
                logic [7:0] got = 8'h00;
                logic [7:0] m = 8'hFF >> (8 - n);
                for (int i = 0; i < n; i++) begin
                    bit v = exp[e][i];
                    int s = k + f * (1 + i);
                    if (!cell_ok(s, f, v)) ok = 1'b0;
                    if (s + f / 2 < log_q.size()) got[i] = log_q[s + f / 2];
                end
                chk(ok, "R2", "data cells span F ticks each", int'(got), int'(exp[e] & m));
                chk(got == (exp[e] & m), "R3", "data bits LSB first", int'(got), int'(exp[e] & m));
            end
            if (cfg_par_en) begin
                bit pv = par_of(exp[e], cfg_len, cfg_par_even);
                int s = k + f * (1 + n);
                chk(cell_ok(s, f, pv), "R4", "parity cell", int'(s < log_q.size() ? log_q[s] : 1'bx), int'(pv));
            end
            begin
                int s = k + f * (1 + n + (cfg_par_en ? 1 : 0));
                int st = stop_of(cfg_baud, cfg_stop);
                chk(cell_ok(s, st, 1'b1), "R5", "stop period high", st, st);
            end
            prev_end = k + flen();
            k = prev_end;
        end
        chk(cell_ok(k, log_q.size() - k, 1'b1), "R6", "no extra frame", log_q.size() - k, 0);
    endtask

    initial begin
        int wd = 0;
        while (wd < 195000) begin
            @(posedge clk);
            wd++;
        end
        chk(1'b0, "R1", "watchdog expired", wd, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] q[$];
        int st;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R1", "txd in reset", txd, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
        chk(tx_rdy == 1'b1, "R1", "rdy after reset", tx_rdy, 1);
        chk(tx_empty == 1'b1, "R1", "empty after reset", tx_empty, 1);

        // R6: write while full is dropped; R9: tx_en low holds the byte
        cts_n = 1'b0;
        tx_en = 1'b0;
        st = log_q.size();
        wr_byte(8'hA5);
        wr_data = 8'h3C; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        wait_ticks(40);
        chk(txd == 1'b1, "R9", "line idle while disabled", txd, 1);
        chk(tx_empty == 1'b0, "R8", "empty low while held", tx_empty, 0);
        tx_en = 1'b1;
        wait_empty();
        q = {8'hA5};
        check_stream(st, q, 1'b0);

        // R9: cts high holds the byte
        cts_n = 1'b1;
        cfg_par_en = 1'b1; cfg_par_even = 1'b1; cfg_len = 2'b00;
        st = log_q.size();
        wr_byte(8'h17);
        wait_ticks(40);
        chk(txd == 1'b1, "R9", "line idle while cts high", txd, 1);
        chk(tx_rdy == 1'b0, "R9", "byte held while cts high", tx_rdy, 0);
        cts_n = 1'b0;
        wait_empty();
        q = {8'h17};
        check_stream(st, q, 1'b0);

        // R7: back-to-back with no gap; R6: ready returns after the move
        cfg_par_en = 1'b0; cfg_len = 2'b11; cfg_stop = 2'b10; cfg_baud = 2'b01;
        st = log_q.size();
        wr_byte(8'hC3);
        wait_ticks(2);
        chk(tx_rdy == 1'b1, "R6", "ready after move to shifter", tx_rdy, 1);
        wr_byte(8'h5A);
        wr_byte(8'h81);
        wait_empty();
        q = {8'hC3, 8'h5A, 8'h81};
        check_stream(st, q, 1'b1);

        // R11: no tick mid-frame freezes the line
        cfg_baud = 2'b10; cfg_stop = 2'b11; cfg_par_en = 1'b1; cfg_par_even = 1'b0;
        st = log_q.size();
        wr_byte(8'h96);
        wait_ticks(40);
        tick_pct = 0;
        @(negedge clk); @(negedge clk);
        begin
            logic held;
            bit same = 1'b1;
            held = txd;
            repeat (30) begin
                @(negedge clk);
                if (txd != held) same = 1'b0;
            end
            chk(same, "R11", "line frozen without ticks", txd, held);
        end
        tick_pct = 100;
        wait_empty();
        q = {8'h96};
        check_stream(st, q, 1'b0);

        // R10: break holds the line low
        send_break = 1'b1;
        @(negedge clk);
        @(negedge clk);
        begin
            bit low = 1'b1;
            repeat (20) begin
                if (txd != 1'b0) low = 1'b0;
                @(negedge clk);
            end
            chk(low, "R10", "line low during break", txd, 0);
        end
        send_break = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(txd == 1'b1, "R10", "line high after break", txd, 1);

        // random formats and tick densities
        for (int it = 0; it < 40; it++) begin
            int r = int'($urandom_range(99));
            int nb = int'($urandom_range(1, 3));
            cfg_baud = (r < 70) ? 2'($urandom_range(0, 1)) : (r < 90) ? 2'b10 : 2'b11;
            cfg_len = 2'($urandom_range(0, 3));
            cfg_par_en = 1'($urandom_range(0, 1));
            cfg_par_even = 1'($urandom_range(0, 1));
            cfg_stop = 2'($urandom_range(0, 3));
            tick_pct = ($urandom_range(1) == 0) ? 100 : 50;
            @(negedge clk);
            st = log_q.size();
            q = {};
            for (int b = 0; b < nb; b++) begin
                logic [7:0] d = 8'($urandom);
                q.push_back(d);
                wr_byte(d);
            end
            wait_empty();
            check_stream(st, q, 1'b0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule